// File: doc/BRIEF.md
# DRAM Bank Timing Guard

This block sits in front of a DRAM command port and decides, cycle by cycle, whether the command on offer may go out. It keeps an open/idle flag and the open row for each of four banks, together with cycle counters that measure how long ago each bank was last activated, read and precharged, and how long ago any bank was activated. A command is accepted or stalled in the cycle it is presented. An accepted command updates the bank state at the next clock edge. A stalled command leaves the state untouched, so the source can simply hold it until it is accepted.

Every spacing rule is an elaboration parameter counted in clock cycles. The default configuration uses a burst of eight, so a read lets its bank be precharged four cycles later. A precharge with address bit 10 set closes every open bank in one command. Refresh, mode programming, the data path and the physical interface are handled elsewhere.

Top module: `bank_timing_guard`

## Requirements
- R1: After synchronous reset every bank is idle, and every spacing rule counts as already met, so an ACT to any bank is accepted in the first cycle after reset.
- R2: An accepted ACT marks its bank open from the next cycle and stores the 13-bit address as that bank's open row, shown on the open-row output at bits [bank*13 +: 13].
- R3: Command encoding is 0 = NOP, 1 = ACT, 2 = READ, 3 = PRE. The accept and stall flags are combinational on the presented command, are mutually exclusive, and are both low for NOP.
- R4: Any two accepted ACTs are at least T_RRD cycles apart. Presented at distance d cycles, the second ACT is accepted only if d >= T_RRD.
- R5: Two accepted ACTs to the same bank are at least T_RC cycles apart.
- R6: An ACT to a bank is stalled until T_RP cycles have passed since that bank was precharged.
- R7: A READ to a bank is stalled until T_RCD cycles have passed since that bank's ACT.
- R8: A PRE that closes a bank is stalled until T_RAS cycles have passed since that bank's ACT.
- R9: A PRE that closes a bank is stalled until BURST_LEN/2 cycles have passed since the last READ to that bank.
- R10: A PRE with address bit 10 low closes only the bank named by the bank address. All other bits of the address are ignored.
- R11: A PRE with address bit 10 high ignores the bank address and closes all open banks at once. It is accepted only if every open bank meets R8 and R9, and it is accepted with no bank open.
- R12: A READ or a bit-10-low PRE to an idle bank, or an ACT to an open bank, raises the illegal flag and is stalled.
- R13: A stalled command changes no open flag and no open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Presented command (R3 encoding) |
| bank_i | input | 2 | Bank address |
| addr_i | input | 13 | Row address for ACT; bit 10 selects all banks on PRE |
| accept_o | output | 1 | Command accepted this cycle |
| stall_o | output | 1 | Non-NOP command refused this cycle |
| illegal_o | output | 1 | Command refused because of the bank's open/idle state |
| bank_open_o | output | 4 | Open flag of each bank |
| open_row_o | output | 52 | Open row of each bank, 13 bits per bank |

## Verification
The hardest case to reach is the gap between same-bank ACT spacing and precharge recovery. A precharge issued as early as T_RAS allows, followed by an ACT as early as T_RP allows, already meets a same-bank rule of T_RAS+T_RP. The bench therefore uses a configuration where T_RC is longer than T_RAS+T_RP, and it sweeps the second ACT across that window so the same-bank rule alone decides. The bench also reaches an all-bank precharge refused by a young second bank. To do so it opens one bank early and a second one just before the precharge, so the refusal comes from the newer bank while the older one is already old enough.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_READ = 2'd2,
        CMD_PRE  = 2'd3
    } cmd_e;

    localparam int ALL_BANKS_BIT = 10;

    function automatic int max_of2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gap_counter.sv
module gap_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] since
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            since <= TOP;
        else if (restart)
            since <= W'(1);
        else if (since != TOP)
            since <= since + W'(1);
    end
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker #(
    parameter int ROW_W = 13,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_act,
    input  logic             do_rd,
    input  logic             do_pre,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row,
    output logic [CW-1:0]    since_act,
    output logic [CW-1:0]    since_rd,
    output logic [CW-1:0]    since_pre
);
    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            row     <= '0;
        end else if (do_act) begin
            is_open <= 1'b1;
            row     <= row_in;
        end else if (do_pre) begin
            is_open <= 1'b0;
        end
    end

    gap_counter #(.W(CW)) act_gap_i (.clk(clk), .rst(rst), .restart(do_act), .since(since_act));
    gap_counter #(.W(CW)) rd_gap_i  (.clk(clk), .rst(rst), .restart(do_rd),  .since(since_rd));
    gap_counter #(.W(CW)) pre_gap_i (.clk(clk), .rst(rst), .restart(do_pre), .since(since_pre));
endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
    import bank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int T_RRD     = 2,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int BURST_LEN = 8,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 cmd_i,
    input  logic [BA_W-1:0]            bank_i,
    input  logic [ROW_W-1:0]           addr_i,
    output logic                       accept_o,
    output logic                       stall_o,
    output logic                       illegal_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_row_o
);
    localparam int T_RDPRE = BURST_LEN / 2;
    localparam int MAXT = max_of2(max_of2(max_of2(T_RRD, T_RCD), max_of2(T_RAS, T_RP)),
                                  max_of2(T_RC, T_RDPRE));
    localparam int CW = $clog2(MAXT + 1);
    localparam logic [CW-1:0] RRD_C   = CW'(T_RRD);
    localparam logic [CW-1:0] RCD_C   = CW'(T_RCD);
    localparam logic [CW-1:0] RAS_C   = CW'(T_RAS);
    localparam logic [CW-1:0] RP_C    = CW'(T_RP);
    localparam logic [CW-1:0] RC_C    = CW'(T_RC);
    localparam logic [CW-1:0] RDPRE_C = CW'(T_RDPRE);

    cmd_e cmd;
    assign cmd = cmd_e'(cmd_i);

    logic [NUM_BANKS-1:0] open_v, rcd_ok, ras_ok, rdp_ok, rp_ok, rc_ok;
    logic [NUM_BANKS-1:0] do_act, do_rd, do_pre;
    logic [CW-1:0]        since_act [NUM_BANKS];
    logic [CW-1:0]        since_rd  [NUM_BANKS];
    logic [CW-1:0]        since_pre [NUM_BANKS];
    logic [CW-1:0]        since_any_act;
    logic                 any_act_ok, illegal, timing_ok, pre_all, accept;

    gap_counter #(.W(CW)) any_act_gap_i (
        .clk(clk), .rst(rst), .restart(accept && cmd == CMD_ACT), .since(since_any_act)
    );
    assign any_act_ok = since_any_act >= RRD_C;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_tracker #(.ROW_W(ROW_W), .CW(CW)) trk_i (
            .clk      (clk),
            .rst      (rst),
            .do_act   (do_act[b]),
            .do_rd    (do_rd[b]),
            .do_pre   (do_pre[b]),
            .row_in   (addr_i),
            .is_open  (open_v[b]),
            .row      (open_row_o[b*ROW_W +: ROW_W]),
            .since_act(since_act[b]),
            .since_rd (since_rd[b]),
            .since_pre(since_pre[b])
        );
        assign rcd_ok[b] = since_act[b] >= RCD_C;
        assign ras_ok[b] = since_act[b] >= RAS_C;
        assign rc_ok[b]  = since_act[b] >= RC_C;
        assign rdp_ok[b] = since_rd[b]  >= RDPRE_C;
        assign rp_ok[b]  = since_pre[b] >= RP_C;

        assign do_act[b] = accept && cmd == CMD_ACT  && bank_i == BA_W'(b);
        assign do_rd[b]  = accept && cmd == CMD_READ && bank_i == BA_W'(b);
        assign do_pre[b] = accept && cmd == CMD_PRE  &&
                           (pre_all ? open_v[b] : bank_i == BA_W'(b));
    end

    always_comb begin
        illegal   = 1'b0;
        timing_ok = 1'b0;
        pre_all   = 1'b0;
        unique case (cmd)
            CMD_ACT: begin
                illegal   = open_v[bank_i];
                timing_ok = rp_ok[bank_i] && rc_ok[bank_i] && any_act_ok;
            end
            CMD_READ: begin
                illegal   = !open_v[bank_i];
                timing_ok = rcd_ok[bank_i];
            end
            CMD_PRE: begin
                if (addr_i[ALL_BANKS_BIT]) begin
                    pre_all   = 1'b1;
                    timing_ok = &(~open_v | (ras_ok & rdp_ok));
                end else begin
                    illegal   = !open_v[bank_i];
                    timing_ok = ras_ok[bank_i] && rdp_ok[bank_i];
                end
            end
            default: ;
        endcase
    end

    assign accept      = cmd != CMD_NOP && !illegal && timing_ok;
    assign accept_o    = accept;
    assign stall_o     = cmd != CMD_NOP && !accept;
    assign illegal_o   = illegal;
    assign bank_open_o = open_v;
endmodule

// File: rtl/bank_timing_guard_chk.sv
module bank_timing_guard_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int T_RRD     = 2,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                       clk,
    input logic                       rst,
    input logic [1:0]                 cmd_i,
    input logic [BA_W-1:0]            bank_i,
    input logic [ROW_W-1:0]           addr_i,
    input logic                       accept_o,
    input logic                       stall_o,
    input logic                       illegal_o,
    input logic [NUM_BANKS-1:0]       bank_open_o,
    input logic [NUM_BANKS*ROW_W-1:0] open_row_o
);
    localparam int GW = $clog2(T_RRD + 2);
    localparam logic [GW-1:0] GTOP = {GW{1'b1}};
    logic [GW-1:0] act_gap;

    always_ff @(posedge clk) begin
        if (rst)
            act_gap <= GTOP;
        else if (accept_o && cmd_i == 2'd1)
            act_gap <= GW'(1);
        else if (act_gap != GTOP)
            act_gap <= act_gap + GW'(1);
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !(accept_o && stall_o)); // R3
    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        cmd_i == 2'd0 |-> !accept_o && !stall_o); // R3
    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (rst)
        accept_o && cmd_i == 2'd1 |-> act_gap >= GW'(T_RRD)); // R4
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        accept_o && cmd_i == 2'd1 |=> bank_open_o[$past(bank_i)]
        && open_row_o[$past(bank_i)*ROW_W +: ROW_W] == $past(addr_i)); // R2
    AST_PRE_ONE: assert property (@(posedge clk) disable iff (rst)
        accept_o && cmd_i == 2'd3 && !addr_i[10] |=> !bank_open_o[$past(bank_i)]); // R10
    AST_PRE_ALL: assert property (@(posedge clk) disable iff (rst)
        accept_o && cmd_i == 2'd3 && addr_i[10] |=> bank_open_o == '0); // R11
    AST_ILLEGAL_STALLS: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> stall_o); // R12
    AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> $stable(bank_open_o) && $stable(open_row_o)); // R13
endmodule

bind bank_timing_guard bank_timing_guard_chk #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .T_RRD(T_RRD)
) chk_i (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .addr_i(addr_i),
    .accept_o(accept_o), .stall_o(stall_o), .illegal_o(illegal_o),
    .bank_open_o(bank_open_o), .open_row_o(open_row_o)
);

// File: tb/bank_timing_guard_tb_top.sv
module bank_timing_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P_RRD = 2, P_RCD = 3, P_RAS = 5, P_RP = 3, P_RC = 11, P_BL = 8;
    localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, RD = 2'd2, PRE = 2'd3;
    localparam logic [12:0] ALLB = 13'h0400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd_i = 2'd0;
    logic [1:0]  bank_i = 2'd0;
    logic [12:0] addr_i = '0;
    logic        accept_o, stall_o, illegal_o;
    logic [3:0]  bank_open_o;
    logic [51:0] open_row_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_timing_guard #(
        .T_RRD(P_RRD), .T_RCD(P_RCD), .T_RAS(P_RAS), .T_RP(P_RP), .T_RC(P_RC), .BURST_LEN(P_BL)
    ) dut_i (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .addr_i(addr_i),
        .accept_o(accept_o), .stall_o(stall_o), .illegal_o(illegal_o),
        .bank_open_o(bank_open_o), .open_row_o(open_row_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] c, input logic [1:0] b, input logic [12:0] a);
        @(negedge clk);
        cmd_i = c; bank_i = b; addr_i = a;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) issue(NOP, 2'd0, 13'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_i = NOP; bank_i = 0; addr_i = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [12:0] row_of(input int b);
        return open_row_o[b*13 +: 13];
    endfunction

    initial begin
        // R1 / R3: reset state and NOP
        do_reset();
        issue(NOP, 2'd0, 13'd0);
        chk("R1 open after reset", bank_open_o, 0);
        chk("R3 NOP accept", accept_o, 0);
        chk("R3 NOP stall", stall_o, 0);
        issue(ACT, 2'd2, 13'h1F0F);
        chk("R1 first ACT accepted", accept_o, 1);
        issue(NOP, 2'd0, 13'd0);
        chk("R2 open flag", bank_open_o, 4'b0100);
        chk("R2 row stored", row_of(2), 13'h1F0F);

        // R4: ACT to ACT on different banks
        for (int d = 1; d <= 4; d++) begin
            do_reset();
            issue(ACT, 2'd0, 13'd5);
            idle(d - 1);
            issue(ACT, 2'd2, 13'd6);
            chk($sformatf("R4 tRRD d=%0d", d), accept_o, (d >= P_RRD));
        end

        // R7: ACT to READ
        for (int d = 1; d <= 5; d++) begin
            do_reset();
            issue(ACT, 2'd1, 13'd9);
            idle(d - 1);
            issue(RD, 2'd1, 13'd0);
            chk($sformatf("R7 tRCD d=%0d", d), accept_o, (d >= P_RCD));
        end

        // R8: ACT to PRE
        for (int d = 1; d <= 7; d++) begin
            do_reset();
            issue(ACT, 2'd1, 13'd9);
            idle(d - 1);
            issue(PRE, 2'd1, 13'd0);
            chk($sformatf("R8 tRAS d=%0d", d), accept_o, (d >= P_RAS));
        end

        // R9: READ to PRE (READ at t=3)
        for (int e = 1; e <= 6; e++) begin
            do_reset();
            issue(ACT, 2'd3, 13'd1);
            idle(2);
            issue(RD, 2'd3, 13'd0);
            idle(e - 1);
            issue(PRE, 2'd3, 13'd0);
            chk($sformatf("R9 read-to-pre e=%0d", e),
                accept_o, (e >= P_BL/2) && (3 + e >= P_RAS));
        end

        // R5: same-bank ACT spacing, PRE at t=5
        for (int d = 8; d <= 13; d++) begin
            do_reset();
            issue(ACT, 2'd0, 13'd1);
            idle(4);
            issue(PRE, 2'd0, 13'd0);
            idle(d - 6);
            issue(ACT, 2'd0, 13'd2);
            chk($sformatf("R5 tRC d=%0d", d), accept_o, (d >= P_RC));
        end

        // R6: PRE to ACT, PRE at t=12
        for (int e = 1; e <= 5; e++) begin
            do_reset();
            issue(ACT, 2'd0, 13'd1);
            idle(11);
            issue(PRE, 2'd0, 13'd0);
            idle(e - 1);
            issue(ACT, 2'd0, 13'd2);
            chk($sformatf("R6 tRP e=%0d", e), accept_o, (e >= P_RP));
        end

        // R10: single-bank PRE with other address bits set
        do_reset();
        issue(ACT, 2'd0, 13'h1ABC);
        idle(1);
        issue(ACT, 2'd1, 13'h0123);
        idle(4);
        issue(PRE, 2'd1, 13'h03FF);
        chk("R10 PRE accepted", accept_o, 1);
        issue(NOP, 2'd0, 13'd0);
        chk("R10 only named bank closed", bank_open_o, 4'b0001);
        chk("R10 other row kept", row_of(0), 13'h1ABC);

        // R11: all-bank PRE, young bank refuses, then succeeds
        do_reset();
        issue(ACT, 2'd0, 13'd7);
        idle(11);
        issue(ACT, 2'd2, 13'd8);
        issue(PRE, 2'd1, ALLB);
        chk("R11 young bank stalls all-PRE", stall_o, 1);
        chk("R11 stall not illegal", illegal_o, 0);
        issue(NOP, 2'd0, 13'd0);
        chk("R13 open kept after stall", bank_open_o, 4'b0101);
        idle(3);
        issue(PRE, 2'd1, ALLB);
        chk("R11 all-PRE accepted", accept_o, 1);
        issue(NOP, 2'd0, 13'd0);
        chk("R11 all banks closed", bank_open_o, 4'b0000);
        issue(PRE, 2'd3, ALLB);
        chk("R11 all-PRE with none open", accept_o, 1);

        // R12 / R13: illegal commands
        do_reset();
        issue(RD, 2'd1, 13'd0);
        chk("R12 READ idle illegal", illegal_o, 1);
        chk("R12 READ idle stall", stall_o, 1);
        issue(PRE, 2'd2, 13'd0);
        chk("R12 PRE idle illegal", illegal_o, 1);
        issue(ACT, 2'd3, 13'h0AAA);
        chk("R12 ACT idle legal", accept_o, 1);
        idle(11);
        issue(ACT, 2'd3, 13'h1555);
        chk("R12 ACT open illegal", illegal_o, 1);
        chk("R12 ACT open stall", stall_o, 1);
        issue(NOP, 2'd0, 13'd0);
        chk("R13 row kept", row_of(3), 13'h0AAA);
        chk("R13 open kept", bank_open_o, 4'b1000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule